// File: doc/BRIEF.md
# CIC Decimation Filter with Optional Stage Pruning

This block lowers the sample rate of a signed fixed-point stream by an integer factor without using any multiplier. The datapath has three parts. A chain of STAGES accumulators runs at the input rate. A rate-reduction point keeps one sample in every DECIM. A chain of STAGES differencers then runs at the reduced rate, and each differencer subtracts the value it saw DIFF_DLY decimated samples earlier. The whole chain behaves like STAGES cascaded boxcar averagers of length DIFF_DLY*DECIM with unit taps, followed by keeping every DECIM-th result.

The internal word is sized for the worst-case gain: MAX_W = IN_W + STAGES*ceil(log2(DIFF_DLY*DECIM)). Accumulators wrap modulo 2^MAX_W, and the differencers undo that wrap. A build-time precision switch picks one of two layouts. In the first, every section keeps the full MAX_W bits. In the second, each section drops a number of low bits taken from a per-section table, which saves registers and adders at the cost of a small added error. The output is the top OUT_W bits of the final section.

Top module: `cic_decimator`

## Requirements
- R1: With TRUNC_EN=0, the k-th output pulse (k from 0) carries bits [MAX_W-1 : MAX_W-OUT_W] of y[m]. Here m = k*DECIM + DECIM-1 - (STAGES-1) counts accepted input samples, y is the input passed through STAGES boxcar sums of length DIFF_DLY*DECIM, and inputs before the first accepted sample count as zero. The value is taken as two's complement, using a floor shift.
- R2: For a constant input x held long enough to fill every boxcar, the full-width output with OUT_W=MAX_W settles at exactly x*(DIFF_DLY*DECIM)^STAGES.
- R3: In full-precision mode, a sustained input of +2^(IN_W-1)-1 or of -2^(IN_W-1), and any mix of those two values, gives the exact R1 result with no overflow.
- R4: out_valid is a single-cycle pulse, raised once for every DECIM accepted inputs. out_data changes only in a cycle where out_valid is high.
- R5: When the DECIM-th input of a group is accepted at clock edge E, out_valid is high in the cycle that follows the STAGES-th rising edge after E.
- R6: Cycles with in_valid low neither advance the decimation count nor change any accumulator, so gaps in the input leave the R1 results unchanged.
- R7: DIFF_DLY may be 1 or 2. With DIFF_DLY=2 the boxcar length doubles to 2*DECIM and MAX_W grows to match.
- R8: With TRUNC_EN=1, section s (accumulators 0..STAGES-1, then differencers STAGES..2*STAGES-1) keeps MAX_W - DROP_TBL[s] bits. The table must not decrease from s=0 to s=2*STAGES-1. The output then stays within 4 output LSBs of the R1 value.
- R9: A synchronous high rst clears every accumulator, differencer history, the decimation count and the outputs. In the cycle after reset out_valid is 0 and out_data is 0, and the following stream yields R1 results as if from power-up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | One-cycle pulse marking a decimated result |
| out_data | output | OUT_W | Signed decimated result, held between pulses |

## Verification
A result is due on the STAGES-th rising edge after the edge that accepts the DECIM-th sample of its group: one register at the rate reduction and one per differencer, with the last differencer serving as the output register. The bench drives and samples on falling edges. A latency test counts those edges one by one and checks that out_valid stays low until exactly the due cycle and drops again one cycle later. All other results are checked by a falling-edge monitor. It pairs each out_valid pulse, in order, with a reference value computed from the logged input history, and each test ends by comparing the number of pulses against the number of accepted samples divided by DECIM.

// File: rtl/cic_pkg.sv
package cic_pkg;

  localparam int unsigned MAX_STAGES = 8;

  // one entry per section: accumulators first, then differencers
  typedef int unsigned drop_tbl_t [2*MAX_STAGES];

  function automatic int unsigned growth_bits(int unsigned stages,
                                              int unsigned decim,
                                              int unsigned dly);
    return stages * $clog2(dly * decim);
  endfunction

endpackage

// File: rtl/cic_decim_ctrl.sv
// Rate-reduction control: counts accepted samples and carries a strobe
// down the differencer pipeline, one register per section.
module cic_decim_ctrl #(
  parameter int unsigned DECIM  = 8,
  parameter int unsigned STAGES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic [STAGES:0]   strobe
);
  localparam int unsigned CW   = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [CW-1:0] LAST = CW'(DECIM - 1);

  logic [CW-1:0] phase;
  logic          take;

  assign take = in_valid && (phase == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      strobe <= '0;
    end else begin
      if (in_valid) begin
        phase <= (phase == LAST) ? '0 : phase + 1'b1;
      end
      strobe <= {strobe[STAGES-1:0], take};
    end
  end
endmodule

// File: rtl/cic_integrator.sv
// One accumulator section. Reads the MAX_W-aligned bus, keeps MAX_W-DROP
// bits, and wraps modulo its width.
module cic_integrator #(
  parameter int unsigned MAX_W = 21,
  parameter int unsigned DROP  = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [MAX_W-1:0] din,
  output logic [MAX_W-1:0] dout
);
  localparam int unsigned KW = MAX_W - DROP;

  logic [KW-1:0] acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
    end else if (en) begin
      acc <= acc + din[MAX_W-1:DROP];
    end
  end

  if (DROP == 0) begin : g_full
    assign dout = acc;
  end else begin : g_pruned
    logic unused_lsb;
    assign unused_lsb = ^din[DROP-1:0];
    assign dout = {acc, {DROP{1'b0}}};
  end
endmodule

// File: rtl/cic_comb.sv
// One differencer section at the decimated rate, delay DLY samples.
module cic_comb #(
  parameter int unsigned MAX_W = 21,
  parameter int unsigned DROP  = 0,
  parameter int unsigned DLY   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [MAX_W-1:0] din,
  output logic [MAX_W-1:0] dout
);
  localparam int unsigned KW = MAX_W - DROP;

  logic [KW-1:0] cur;
  logic [KW-1:0] hist [DLY];
  logic [KW-1:0] res;

  assign cur = din[MAX_W-1:DROP];

  always_ff @(posedge clk) begin
    if (rst) begin
      res <= '0;
      for (int i = 0; i < DLY; i++) hist[i] <= '0;
    end else if (en) begin
      res     <= cur - hist[DLY-1];
      hist[0] <= cur;
      for (int i = 1; i < DLY; i++) hist[i] <= hist[i-1];
    end
  end

  if (DROP == 0) begin : g_full
    assign dout = res;
  end else begin : g_pruned
    logic unused_lsb;
    assign unused_lsb = ^din[DROP-1:0];
    assign dout = {res, {DROP{1'b0}}};
  end
endmodule

// File: rtl/cic_decimator.sv
module cic_decimator #(
  parameter int unsigned        IN_W     = 12,
  parameter int unsigned        OUT_W    = 16,
  parameter int unsigned        STAGES   = 3,
  parameter int unsigned        DECIM    = 8,
  parameter int unsigned        DIFF_DLY = 1,
  parameter bit                 TRUNC_EN = 1'b0,
  parameter cic_pkg::drop_tbl_t DROP_TBL = '{0, 0, 1, 1, 2, 2, 3, 3,
                                             4, 4, 4, 4, 5, 5, 5, 5}
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int unsigned GROWTH = cic_pkg::growth_bits(STAGES, DECIM, DIFF_DLY);
  localparam int unsigned MAX_W  = IN_W + GROWTH;

  logic [MAX_W-1:0] ibus [STAGES+1];
  logic [MAX_W-1:0] cbus [STAGES+1];
  logic [STAGES:0]  strobe;

  assign ibus[0] = {{GROWTH{in_data[IN_W-1]}}, in_data};

  cic_decim_ctrl #(.DECIM(DECIM), .STAGES(STAGES)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .strobe(strobe)
  );

  for (genvar k = 0; k < STAGES; k++) begin : g_integ
    localparam int unsigned D = TRUNC_EN ? DROP_TBL[k] : 0;
    cic_integrator #(.MAX_W(MAX_W), .DROP(D)) u_int (
      .clk(clk), .rst(rst), .en(in_valid), .din(ibus[k]), .dout(ibus[k+1])
    );
  end

  assign cbus[0] = ibus[STAGES];

  for (genvar j = 0; j < STAGES; j++) begin : g_comb
    localparam int unsigned D = TRUNC_EN ? DROP_TBL[STAGES + j] : 0;
    cic_comb #(.MAX_W(MAX_W), .DROP(D), .DLY(DIFF_DLY)) u_comb (
      .clk(clk), .rst(rst), .en(strobe[j]), .din(cbus[j]), .dout(cbus[j+1])
    );
  end

  assign out_valid = strobe[STAGES];
  assign out_data  = cbus[STAGES][MAX_W-1 -: OUT_W];

  if (OUT_W < MAX_W) begin : g_narrow
    logic unused_tail;
    assign unused_tail = ^cbus[STAGES][MAX_W-OUT_W-1:0];
  end
endmodule

// File: rtl/cic_decimator_chk.sv
module cic_decimator_chk #(
  parameter int unsigned DECIM  = 8,
  parameter int unsigned STAGES = 3,
  parameter int unsigned OUT_W  = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_data
);
  localparam int unsigned CW   = (DECIM > 1) ? $clog2(DECIM) : 1;
  localparam logic [CW-1:0] LAST = CW'(DECIM - 1);

  // independent model of when a result is due
  logic [CW-1:0]   seen;
  logic [STAGES:0] due;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen <= '0;
      due  <= '0;
    end else begin
      if (in_valid) seen <= (seen == LAST) ? '0 : seen + 1'b1;
      due <= {due[STAGES-1:0], in_valid && (seen == LAST)};
    end
  end

  // R5 / R6: pulse lands exactly when the model says, gaps not counted
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    out_valid == due[STAGES]);

  // R4: result held between pulses
  a_r4_hold_between: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_data) |-> out_valid);

  if (DECIM > 1) begin : g_pulse
    // R4: one cycle wide
    a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);
  end

  // R9: outputs cleared on leaving reset
  a_r9_reset_clear: assert property (@(posedge clk)
    $fell(rst) |-> (!out_valid && out_data == '0));
endmodule

bind cic_decimator cic_decimator_chk #(
  .DECIM(DECIM), .STAGES(STAGES), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_data(out_data)
);

// File: tb/cic_decimator_tb.sv
module cic_decimator_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IN_W = 12;
  localparam int N    = 3;
  localparam int M    = 8;
  localparam int WA   = IN_W + N * $clog2(M);
  localparam int WB   = IN_W + N * $clog2(2 * M);
  localparam int WT   = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [IN_W-1:0] in_data = '0;
  logic va, vb, vt;
  logic signed [WA-1:0] da;
  logic signed [WB-1:0] db;
  logic signed [WT-1:0] dt;

  always #(CLK_PERIOD/2) clk = ~clk;

  // full precision, delay 1, full output width
  cic_decimator #(.IN_W(IN_W), .OUT_W(WA), .STAGES(N), .DECIM(M),
                  .DIFF_DLY(1), .TRUNC_EN(1'b0)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(va), .out_data(da));

  // full precision, delay 2
  cic_decimator #(.IN_W(IN_W), .OUT_W(WB), .STAGES(N), .DECIM(M),
                  .DIFF_DLY(2), .TRUNC_EN(1'b0)) u_dut_r2 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(vb), .out_data(db));

  // pruned sections, narrowed output
  cic_decimator #(.IN_W(IN_W), .OUT_W(WT), .STAGES(N), .DECIM(M),
                  .DIFF_DLY(1), .TRUNC_EN(1'b1)) u_dut_tr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(vt), .out_data(dt));

  int n_tests = 0;
  int n_fail  = 0;
  longint xs [4096];
  int nx = 0;
  int ka = 0, kb = 0, kt = 0;
  longint last_a = 0, last_b = 0, last_t = 0;
  longint taps [2][64];
  int tlen [2];
  bit done = 1'b0;

  task automatic check(bit ok, string req, longint act, longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic build_taps();
    for (int ri = 0; ri < 2; ri++) begin
      int L = (ri + 1) * M;
      int len = 1;
      longint tmp [64];
      for (int a = 0; a < 64; a++) taps[ri][a] = 0;
      taps[ri][0] = 1;
      for (int s = 0; s < N; s++) begin
        for (int a = 0; a < 64; a++) tmp[a] = 0;
        for (int a = 0; a < len; a++)
          for (int b = 0; b < L; b++) tmp[a+b] += taps[ri][a];
        len = len + L - 1;
        for (int a = 0; a < 64; a++) taps[ri][a] = tmp[a];
      end
      tlen[ri] = len;
    end
  endtask

  function automatic longint ref_out(int ri, int k);
    int m = k * M + M - 1 - (N - 1);
    longint s = 0;
    for (int j = 0; j < tlen[ri]; j++)
      if (m - j >= 0 && m - j < nx) s += taps[ri][j] * xs[m-j];
    return s;
  endfunction

  // in-order comparison of every pulse against the reference (R1, R7, R8)
  always @(negedge clk) begin
    longint e;
    longint g;
    if (!rst) begin
      if (va) begin
        e = ref_out(0, ka); g = longint'(da);
        check(g == e, "R1", g, e);
        last_a = g; ka++;
      end
      if (vb) begin
        e = ref_out(1, kb); g = longint'(db);
        check(g == e, "R7", g, e);
        last_b = g; kb++;
      end
      if (vt) begin
        e = ref_out(0, kt) >>> (WA - WT); g = longint'(dt);
        check(g - e <= 4 && e - g <= 4, "R8", g, e);
        last_t = g; kt++;
      end
    end
  end

  task automatic push(bit v, longint x);
    @(negedge clk);
    in_valid = v;
    in_data  = x[IN_W-1:0];
    if (v) begin
      xs[nx] = x;
      nx++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; in_data = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(!va && da == 0, "R9", longint'(da), 0);
    check(!vt && dt == 0, "R9", longint'(dt), 0);
    nx = 0; ka = 0; kb = 0; kt = 0;
    rst = 1'b0;
  endtask

  task automatic flush_count(string req);
    repeat (N + 3) push(1'b0, 0);
    check(ka == nx / M, req, ka, nx / M);
    check(kb == nx / M, req, kb, nx / M);
    check(kt == nx / M, req, kt, nx / M);
  endtask

  task automatic t_latency();  // R5, R4
    do_reset();
    for (int i = 0; i < M; i++) push(1'b1, 60 * i - 200);
    @(posedge clk);
    for (int k = 1; k <= N; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      check(va == 1'b0, "R5 early", va, 0);
      @(posedge clk);
    end
    @(negedge clk);
    check(va == 1'b1, "R5 due", va, 1);
    @(negedge clk);
    check(va == 1'b0, "R4 pulse", va, 0);
    flush_count("R4");
  endtask

  task automatic t_dc();  // R2
    do_reset();
    repeat (8 * M) push(1'b1, 1000);
    flush_count("R4");
    check(last_a == 1000 * 512, "R2", last_a, 1000 * 512);
    check(last_b == 1000 * 4096, "R2 R7", last_b, 1000 * 4096);
    check(last_t - 16000 <= 4 && 16000 - last_t <= 4, "R8", last_t, 16000);
  endtask

  task automatic t_full_scale();  // R3
    do_reset();
    repeat (8 * M) push(1'b1, 2047);
    flush_count("R3");
    check(last_a == 2047 * 512, "R3", last_a, 2047 * 512);
    repeat (8 * M) push(1'b1, -2048);
    flush_count("R3");
    check(last_a == -2048 * 512, "R3", last_a, -2048 * 512);
    check(last_b == -2048 * 4096, "R3", last_b, -2048 * 4096);
    for (int i = 0; i < 20 * M; i++) push(1'b1, ($urandom % 2) ? 2047 : -2048);
    flush_count("R3");
  endtask

  task automatic t_random();  // R1, R7, R8
    do_reset();
    for (int i = 0; i < 40 * M; i++) begin
      logic signed [IN_W-1:0] r;
      r = IN_W'($urandom);
      push(1'b1, longint'(r));
    end
    flush_count("R1");
  endtask

  task automatic t_gaps();  // R6
    do_reset();
    for (int i = 0; i < 60 * M; i++) begin
      logic signed [IN_W-1:0] r;
      r = IN_W'($urandom);
      push(($urandom % 3) != 0, longint'(r));
    end
    flush_count("R6");
  endtask

  task automatic t_mid_reset();  // R9
    for (int i = 0; i < 13; i++) push(1'b1, 1500 - 100 * i);
    do_reset();
    for (int i = 0; i < 5 * M; i++) push(1'b1, 37 * i - 700);
    flush_count("R9");
  endtask

  initial begin
    build_taps();
    t_latency();
    t_dc();
    t_full_scale();
    t_random();
    t_gaps();
    t_mid_reset();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule